// File: doc/BRIEF.md
# Register-Map Serial Slave

This block lets a host processor reach a small bank of 8-bit control registers over a two-wire, open-drain serial bus (I2C-compatible). The slave watches SCL and SDA from the system clock domain. It recognises START and STOP conditions and matches a 7-bit device address, one bit of which comes from a board strap. It answers with ACK or NACK on the ninth clock of each byte. After the address, the first byte a writer sends selects a register (the subaddress). Each later byte lands in the next register up. A reader issues a repeated START and then streams registers out from the stored pointer.

The ends of the map are defined. A subaddress outside the bank is refused and the slave drops back to idle. A write that steps past the last register is refused and not stored. A read that steps past the last register keeps returning the last one until the master declines with a NACK. Register 0 is a power-mode register. Its fields are brought out as plain control pins for sleep, PLL power-down and one enable per DAC. Every register stays readable and writable whatever those pins say.

The bus side has no back-pressure: the slave never stretches SCL, and each byte is taken or refused within its own ninth clock. The control outputs are level signals that follow register 0 directly.

Top module: `i2c_regmap_slave`

## Requirements
- R1: After reset, register 0 holds 0x12: sleep_en = 0, pll_pd = 1, dac_en = 3'b100. SDA is released (sda_oe = 0).
- R2: The device answers the 7-bit address {6'b110101, addr_strap}, which is the 8-bit write byte 0xD4 with the strap low and 0xD6 with it high. It acknowledges by pulling SDA low during the ninth clock.
- R3: A byte after START that does not match the address gets a NACK. The slave then ignores all bus activity until the next START, and no register changes.
- R4: In a write, the byte after the address is the subaddress. Each following data byte is stored at the pointer, which then advances by one. Every accepted byte is acknowledged.
- R5: A subaddress at or above the register count (16 by default, so 0x10 and up) gets a NACK and returns the slave to idle. Later bytes in that transfer are NACKed and not stored.
- R6: A read that runs past the last register (0x0F) keeps returning that register's contents.
- R7: A write byte that arrives after register 0x0F has been written is not stored, gets a NACK, and returns the slave to idle.
- R8: A START or a STOP seen at any point, even inside a byte, abandons the current transfer. A partial byte is never stored.
- R9: Register 0 fields drive the outputs: bit 0 drives sleep_en, bit 1 drives pll_pd, and bits 4:2 drive dac_en[2:0].
- R10: A read starts with a repeated START and R/W = 1. Data comes MSB first from the stored pointer. A master ACK moves on to the next register. A master NACK ends the read with SDA released.
- R11: SDA is open-drain (sda_oe pulls it low) and the slave changes it only while SCL is low, so data stays stable through each SCL high phase.
- R12: Registers can be written and read back while sleep_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pulls SDA low when 1, releases it when 0 |
| addr_strap | input | 1 | Strap selecting the device address LSB |
| sleep_en | output | 1 | Sleep-mode control from register 0 |
| pll_pd | output | 1 | PLL/oversampling power-down from register 0 |
| dac_en | output | 3 | Per-DAC power-on enables from register 0 |

## Verification
A wrong bit counter or state shows up on the bus within one byte. The ninth-clock ACK appears on the wrong clock, or the read data comes out shifted, and the bench samples both at the SCL high phase. A pointer that advances wrongly or fails to saturate shows up as a wrong value on the next readback, or as an ACK where a NACK belongs at the map's end. Register-file corruption shows up on the power-control pins straight after the byte's ninth clock, or on a later readback. Aborted and mis-addressed transfers are judged by those same pins and readbacks staying unchanged.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WR,
    ST_RD
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic [1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= synced;
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev_q[0];
  assign scl_fall  = ~synced[0] & prev_q[0];
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_det  = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int          NUM_REGS  = 16,
  parameter int          ADDR_W    = 4,
  parameter logic [7:0]  PWR_RESET = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        pwr_reg
);
  logic [NUM_REGS-1:0][7:0] regs;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = (g == 0) ? PWR_RESET : 8'h00;
    logic [7:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     val_q <= RST_VAL;
      else if (wr_en && wr_addr == ADDR_W'(g))        val_q <= wr_data;
    end
    assign regs[g] = val_q;
  end

  assign rd_data = regs[rd_addr];
  assign pwr_reg = regs[0];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 4,
  parameter int PTR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [6:0]        dev_addr,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output i2cs_state_e       state,
  output logic [PTR_W-1:0]  ptr
);
  localparam logic [PTR_W-1:0]  PTR_END  = PTR_W'(NUM_REGS);
  localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] ADR_LAST = ADDR_W'(NUM_REGS - 1);

  i2cs_state_e       state_q;
  logic [3:0]        bitcnt_q;   // SCL rises counted within a byte, 9 = ack clock seen
  logic [7:0]        shift_q;
  logic [7:0]        tx_q;
  logic              rw_q;
  logic              oe_q;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;
  logic [PTR_W-1:0]  ptr_q;

  // Past-end pointer reads the last register
  assign rd_addr = (ptr_q >= PTR_LAST) ? ADR_LAST : ptr_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      ptr_q     <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (stop_det) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        bitcnt_q <= '0;
      end else if (start_det) begin
        state_q  <= ST_ADDR;
        oe_q     <= 1'b0;
        bitcnt_q <= '0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt_q < 4'd8) begin
            shift_q  <= {shift_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (bitcnt_q == 4'd8) begin
            if (state_q == ST_RD && sda_s) begin
              state_q <= ST_IDLE;                 // master declined more data
            end else begin
              if (state_q == ST_RD && ptr_q < PTR_LAST) ptr_q <= ptr_q + 1'b1;
              bitcnt_q <= 4'd9;
            end
          end
        end else if (scl_fall) begin
          if (bitcnt_q == 4'd8) begin
            unique case (state_q)
              ST_ADDR: begin
                if (shift_q[7:1] == dev_addr) begin
                  oe_q <= 1'b1;
                  rw_q <= shift_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_SUB: begin
                if (int'(shift_q) < NUM_REGS) begin
                  ptr_q <= PTR_W'(shift_q);
                  oe_q  <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_WR: begin
                if (ptr_q < PTR_END) begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q[ADDR_W-1:0];
                  wr_data_q <= shift_q;
                  ptr_q     <= ptr_q + 1'b1;
                  oe_q      <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_RD:   oe_q <= 1'b0;
              default: oe_q <= 1'b0;
            endcase
          end else if (bitcnt_q == 4'd9) begin
            bitcnt_q <= '0;
            unique case (state_q)
              ST_ADDR: begin
                if (rw_q) begin
                  state_q <= ST_RD;
                  tx_q    <= rd_data;
                  oe_q    <= ~rd_data[7];
                end else begin
                  state_q <= ST_SUB;
                  oe_q    <= 1'b0;
                end
              end
              ST_SUB: begin
                state_q <= ST_WR;
                oe_q    <= 1'b0;
              end
              ST_RD: begin
                tx_q <= rd_data;
                oe_q <= ~rd_data[7];
              end
              default: oe_q <= 1'b0;
            endcase
          end else if (state_q == ST_RD && bitcnt_q != 4'd0) begin
            oe_q <= ~tx_q[3'(4'd7 - bitcnt_q)];
          end
        end
      end
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign state   = state_q;
  assign ptr     = ptr_q;
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave
  import i2cs_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         NUM_DAC     = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] BASE_ADDR   = 7'h6A,
  parameter logic [7:0] PWR_RESET   = 8'h12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               addr_strap,
  output logic               sleep_en,
  output logic               pll_pd,
  output logic [NUM_DAC-1:0] dac_en
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int PTR_W  = $clog2(NUM_REGS + 1);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data, pwr_reg;
  i2cs_state_e       state;
  logic [PTR_W-1:0]  ptr;
  logic [6:0]        dev_addr;

  assign dev_addr = {BASE_ADDR[6:1], addr_strap};

  i2cs_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .state(state), .ptr(ptr)
  );

  i2cs_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .PWR_RESET(PWR_RESET)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwr_reg(pwr_reg)
  );

  assign sleep_en = pwr_reg[0];
  assign pll_pd   = pwr_reg[1];
  assign dac_en   = pwr_reg[2 +: NUM_DAC];
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = $clog2(NUM_REGS),
  parameter int PTR_W    = $clog2(NUM_REGS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input i2cs_state_e       state,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        pwr_reg,
  input logic [PTR_W-1:0]  ptr
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);  // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);  // R8
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);  // R4
  AST_PWR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_reg != $past(pwr_reg)) |-> $past(wr_en && wr_addr == '0));  // R9
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(NUM_REGS));  // R7
endmodule

bind i2c_regmap_slave i2cs_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .state(state),
  .wr_en(wr_en), .wr_addr(wr_addr), .pwr_reg(pwr_reg), .ptr(ptr)
);

// File: tb/i2c_regmap_slave_bench.sv
module i2c_regmap_slave_bench;
  localparam int Q = 8;  // clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b0;
  logic       sda_oe, sleep_en, pll_pd;
  logic [2:0] dac_en;
  logic       sda_line;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regmap_slave u_i2c_regmap_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .sleep_en(sleep_en), .pll_pd(pll_pd), .dac_en(dac_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = v[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    end
  endtask

  // returns the line level at the ninth clock: 0 = ACK
  task automatic send_byte(input logic [7:0] v, output logic ack);
    send_bits(v, 8);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic early, late;
    bit stable = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1;
      repeat (2) @(negedge clk);
      early = sda_line;
      wq(); d[i] = sda_line; wq();
      late = sda_line;
      if (early !== late) stable = 1'b0;
      scl = 1'b0;
    end
    chk("R11 data stable while SCL high", stable, 1'b1);
    sda_m = nack; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic chk_pwr(input string req, input logic [7:0] exp);
    chk(req, {27'd0, dac_en, pll_pd, sleep_en}, {27'd0, exp[4:0]});
  endtask

  // Address-write plus subaddress; returns both ACK bits packed
  task automatic open_write(input logic [7:0] sub, output logic [1:0] acks);
    logic a0, a1;
    bus_start(); send_byte(8'hD4, a0); send_byte(sub, a1);
    acks = {a0, a1};
  endtask

  task automatic read_from(input logic [7:0] sub, input int n, output logic [31:0] data);
    logic [1:0] acks;
    logic a;
    logic [7:0] d;
    open_write(sub, acks);
    bus_start(); send_byte(8'hD5, a);
    data = '0;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      data = {data[23:0], d};
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk_pwr("R1 power register reset", 8'h12);
    chk("R1 sda released after reset", sda_oe, 1'b0);
  endtask

  task automatic t_address();
    logic a;
    strap = 1'b0;
    bus_start(); send_byte(8'hD6, a); bus_stop(); chk("R3 other address NACK", a, 1'b1);
    bus_start(); send_byte(8'hD4, a); bus_stop(); chk("R2 0xD4 ACK strap low", a, 1'b0);
    strap = 1'b1; wq();
    bus_start(); send_byte(8'hD6, a); bus_stop(); chk("R2 0xD6 ACK strap high", a, 1'b0);
    bus_start(); send_byte(8'hD4, a); bus_stop(); chk("R3 0xD4 NACK strap high", a, 1'b1);
    strap = 1'b0; wq();
  endtask

  task automatic t_mismatch_ignored();
    logic a0, a1, a2;
    bus_start(); send_byte(8'hD0, a0); send_byte(8'h00, a1); send_byte(8'h1D, a2); bus_stop();
    chk("R3 mismatch NACK", a0, 1'b1);
    chk("R3 later bytes NACK", {a1, a2}, 2'b11);
    chk_pwr("R3 registers untouched", 8'h12);
  endtask

  task automatic t_write_autoinc();
    logic [1:0] acks;
    logic a;
    logic [31:0] rd;
    open_write(8'h01, acks);
    chk("R4 address and subaddress ACK", acks, 2'b00);
    send_byte(8'h11, a); chk("R4 data ACK 1", a, 1'b0);
    send_byte(8'h22, a); chk("R4 data ACK 2", a, 1'b0);
    send_byte(8'h33, a); chk("R4 data ACK 3", a, 1'b0);
    bus_stop();
    read_from(8'h01, 3, rd);
    chk("R4 R10 auto-increment readback", rd, 32'h00112233);
    chk("R10 sda released after master NACK", sda_oe, 1'b0);
  endtask

  task automatic t_power_and_sleep();
    logic [1:0] acks;
    logic a;
    logic [31:0] rd;
    open_write(8'h00, acks); send_byte(8'h1D, a); bus_stop();
    chk_pwr("R9 power fields 0x1D", 8'h1D);
    open_write(8'h00, acks); send_byte(8'h0A, a); bus_stop();
    chk_pwr("R9 power fields 0x0A", 8'h0A);
    open_write(8'h00, acks); send_byte(8'h01, a); bus_stop();
    chk("R12 sleep active", sleep_en, 1'b1);
    open_write(8'h05, acks); send_byte(8'hA5, a); bus_stop();
    chk("R12 write ACK in sleep", a, 1'b0);
    read_from(8'h05, 1, rd);
    chk("R12 readback in sleep", rd[7:0], 8'hA5);
    open_write(8'h00, acks); send_byte(8'h12, a); bus_stop();
    chk_pwr("R9 power restored", 8'h12);
  endtask

  task automatic t_invalid_sub();
    logic [1:0] acks;
    logic a;
    logic [31:0] rd;
    open_write(8'h0F, acks); send_byte(8'h5A, a); bus_stop();
    open_write(8'h10, acks);
    chk("R5 invalid subaddress NACK", acks, 2'b01);
    send_byte(8'h77, a); bus_stop();
    chk("R5 following byte NACK", a, 1'b1);
    read_from(8'h0F, 1, rd);
    chk("R5 no store after invalid subaddress", rd[7:0], 8'h5A);
    chk_pwr("R5 power register untouched", 8'h12);
  endtask

  task automatic t_write_past_end();
    logic [1:0] acks;
    logic a0, a1, a2, a3;
    logic [31:0] rd;
    open_write(8'h0E, acks);
    send_byte(8'h61, a0); send_byte(8'h62, a1); send_byte(8'h63, a2); send_byte(8'h64, a3);
    bus_stop();
    chk("R7 in-range writes ACK", {a0, a1}, 2'b00);
    chk("R7 past-end write NACK", a2, 1'b1);
    chk("R7 idle after past-end", a3, 1'b1);
    read_from(8'h0E, 2, rd);
    chk("R7 last registers intact", rd[15:0], 16'h6162);
    chk_pwr("R7 no wrap into register 0", 8'h12);
  endtask

  task automatic t_read_past_end();
    logic [31:0] rd;
    read_from(8'h0E, 4, rd);
    chk("R6 read repeats last register", rd, 32'h61626262);
    chk("R10 release after NACK", sda_oe, 1'b0);
  endtask

  task automatic t_abort();
    logic [1:0] acks;
    logic a;
    logic [31:0] rd;
    open_write(8'h00, acks); send_bits(8'hFF, 4); bus_stop();
    chk_pwr("R8 STOP mid-byte drops data", 8'h12);
    open_write(8'h03, acks); send_bits(8'hC3, 3);
    bus_start(); send_byte(8'hD4, a);
    chk("R8 address after mid-byte START ACK", a, 1'b0);
    send_byte(8'h03, a); send_byte(8'h3C, a); bus_stop();
    chk("R8 new transfer data ACK", a, 1'b0);
    read_from(8'h03, 1, rd);
    chk("R8 register after restart", rd[7:0], 8'h3C);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();
    t_reset();
    t_address();
    t_mismatch_ignored();
    t_write_autoinc();
    t_power_and_sleep();
    t_invalid_sub();
    t_write_past_end();
    t_read_past_end();
    t_abort();
    wq(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule